// File: doc/BRIEF.md
# Feed-Sequence Protected Watchdog

This block is a down-counting supervisory timer for a chip's peripheral domain. Software writes a reload constant, sets an enable bit and chooses between an interrupt-only response and a reset request, then keeps the system alive by writing a two-byte key to a feed location. A counter decrements once every four clocks while the watchdog is active. If the count runs out, or a key sequence is malformed, the block raises a sticky timeout flag. If reset mode is active, it also pulses a reset request to the chip's reset logic.

Enabling the watchdog is one-way: software can set the enable bit but cannot clear it. The enable bit, the chosen mode and the reload constant take effect only when a valid feed arrives, so a watchdog that has just been enabled does not count until it is first fed. Registers are reached through a single-cycle bus with word indices: 0 is control, 1 is reload, 2 is feed and 3 is the live count. Read data depends combinationally on the address.

Top module: `wdt_guard`

## Requirements
- R1: After reset, control reads 0, the count reads 0, reload reads all ones, and both `wdt_irq` and `wdt_rst_req` are low.
- R2: Control bit 0 (enable) is set by writing 1 to it. Writing 0 to it leaves it set. Only `rst_n` or a watchdog reset fault clears it.
- R3: A valid feed loads the counter with the reload value, raised to 256 when it is below 256. The reload register itself reads back the raw written value.
- R4: While active, the count drops by one every 4 clocks after the feed. With effective load L, the flag rises exactly 4·L clocks after the clock edge that accepted the feed, and the count reads 0 at that point.
- R5: A valid feed during counting restores the count to the effective reload value and restarts the 4-clock phase.
- R6: A valid feed is a write of 0xAA (bits 7:0) to the feed register, followed on the very next bus access by a write of 0x55. Three cases are faults while active: a first byte other than 0xAA, 0xAA followed by any other access, and 0xAA followed by another 0xAA. While inactive, feed bytes of any value are ignored.
- R7: Enable (bit 0) and reset mode (bit 1) have no effect until a valid feed arrives while enable is set. Until then, the count does not move and control bit 3 (active) stays 0.
- R8: The timeout flag (control bit 2, also driven on `wdt_irq`) stays set until software writes control with bit 2 = 1. A write with bit 2 = 0 leaves it set.
- R9: A fault in reset mode gives a `wdt_rst_req` pulse one clock long and clears enable and active. A fault in interrupt mode sets only the flag, leaving enable set and `wdt_rst_req` low.
- R10: After any fault the counter stops and holds its value, and control bit 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_irq | output | 1 | Sticky timeout flag |
| wdt_rst_req | output | 1 | One-clock reset request |

## Verification
A wrong prescaler phase or counter value shows up at the count register within 4 clocks of a feed, and it moves the flag edge away from the computed 4·L position. A wrong feed-tracking state either hides a fault or invents one, and the flag or reset pulse shows it at the edge of the offending access. A corrupted enable or active bit shows up at once in the control read-back, and at the next feed as a count that moves or fails to move. The sweep covers reload values on both sides of the 256 floor and every kind of feed violation in both modes.

// File: rtl/wdt_pkg.sv
// Shared definitions for the watchdog: register indices, feed keys and
// control-bit positions. Assumes a two-bit word index on the bus.
package wdt_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_COUNT  = 2'd3
    } wdt_reg_e;

    localparam logic [7:0] FEED_FIRST  = 8'hAA;
    localparam logic [7:0] FEED_SECOND = 8'h55;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_RST_BIT  = 1;
    localparam int CTRL_FLAG_BIT = 2;
    localparam int CTRL_ACT_BIT  = 3;
endpackage

// File: rtl/wdt_prescale.sv
// Divides the clock by DIV into a one-cycle tick while run is high.
// Assumes restart aligns the phase so the first tick follows DIV clocks.
module wdt_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: cleared on reset, restart or idle, wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign tick = run && (phase == LAST);

    generate
        if (DIV > 1) begin : g_chk
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick repeated on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/wdt_feed_seq.sv
// Tracks the two-byte feed key across consecutive bus accesses and
// reports a good or bad sequence in the cycle of the deciding access.
// Assumes acc marks every bus access and feed_wr a write to the feed slot.
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       feed_wr,
    input  logic [7:0] wbyte,
    output logic       good,
    output logic       bad
);
    logic seen_first, seen_nxt;

    // Decide the outcome of this access and the next tracking state.
    always_comb begin
        good     = 1'b0;
        bad      = 1'b0;
        seen_nxt = seen_first;
        if (acc) begin
            if (seen_first) begin
                seen_nxt = 1'b0;
                if (feed_wr && wbyte == FEED_SECOND) good = 1'b1;
                else                                 bad  = 1'b1;
            end else if (feed_wr) begin
                if (wbyte == FEED_FIRST) seen_nxt = 1'b1;
                else                     bad      = 1'b1;
            end
        end
    end

    // Hold whether the first key byte was the latest access.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_first <= 1'b0;
        else        seen_first <= seen_nxt;
    end

    p_half_from_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_first |-> $past(acc && feed_wr && wbyte == FEED_FIRST))
        else $error("half-sequence state without a first key write");
endmodule

// File: rtl/wdt_count.sv
// Down counter with a floor on the loaded value; flags expiry on the
// tick that takes the count to zero. Assumes load and run come from the top.
module wdt_count #(
    parameter int CW       = 32,
    parameter int MIN_LOAD = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] value,
    output logic          expire
);
    localparam logic [CW-1:0] FLOOR = CW'(MIN_LOAD);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] clamped;

    assign clamped = (load_val < FLOOR) ? FLOOR : load_val;
    assign expire  = run && tick && !load && (value <= ONE);

    // Count register: load wins, then one step per tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= clamped;
        end else if (run && tick) begin
            value <= (value <= ONE) ? '0 : value - ONE;
        end
    end

    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value >= FLOOR)
        else $error("loaded count below floor");
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && value > ONE) |=> value == $past(value) - ONE)
        else $error("count step wrong");
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(value))
        else $error("count moved while stopped");
endmodule

// File: rtl/wdt_guard.sv
// Watchdog top: register file, sticky enable, mode latching on feed,
// fault handling. Assumes single-cycle bus accesses and that the chip
// reset logic consumes wdt_rst_req.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRESCALE   = 4,
    parameter int MIN_RELOAD = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req
);
    logic en_q, rst_cfg_q, rst_act_q, active_q, flag_q, rst_req_q;
    logic [CNT_W-1:0] reload_q, count;
    logic wr_ctrl, wr_reload, wr_feed;
    logic feed_good, feed_bad, arm, fault, tick, expire;

    assign wr_ctrl   = bus_valid && bus_write && (bus_addr == REG_CTRL);
    assign wr_reload = bus_valid && bus_write && (bus_addr == REG_RELOAD);
    assign wr_feed   = bus_valid && bus_write && (bus_addr == REG_FEED);

    wdt_feed_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (bus_valid),
        .feed_wr (wr_feed),
        .wbyte   (bus_wdata[7:0]),
        .good    (feed_good),
        .bad     (feed_bad)
    );

    assign arm   = feed_good && en_q;
    assign fault = active_q && (expire || feed_bad);

    wdt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active_q),
        .restart (arm),
        .tick    (tick)
    );

    wdt_count #(.CW(CNT_W), .MIN_LOAD(MIN_RELOAD)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (reload_q),
        .run      (active_q),
        .tick     (tick),
        .value    (count),
        .expire   (expire)
    );

    // Enable: set-only from software, cleared by a reset-mode fault.
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= 1'b0;
        else if (fault && rst_act_q)  en_q <= 1'b0;
        else if (wr_ctrl && bus_wdata[CTRL_EN_BIT]) en_q <= 1'b1;
    end

    // Requested mode and reload constant, freely written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cfg_q <= 1'b0;
            reload_q  <= '1;
        end else begin
            if (wr_ctrl)   rst_cfg_q <= bus_wdata[CTRL_RST_BIT];
            if (wr_reload) reload_q  <= bus_wdata;
        end
    end

    // Active state and latched mode: armed by a valid feed, dropped on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            rst_act_q <= 1'b0;
        end else if (fault) begin
            active_q  <= 1'b0;
        end else if (arm) begin
            active_q  <= 1'b1;
            rst_act_q <= rst_cfg_q;
        end
    end

    // Sticky flag and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= fault && rst_act_q;
            if (fault)                                    flag_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    // Read mux, combinational on the address.
    always_comb begin
        bus_rdata = '0;
        case (wdt_reg_e'(bus_addr))
            REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en_q;
                bus_rdata[CTRL_RST_BIT]  = rst_cfg_q;
                bus_rdata[CTRL_FLAG_BIT] = flag_q;
                bus_rdata[CTRL_ACT_BIT]  = active_q;
            end
            REG_RELOAD: bus_rdata = reload_q;
            REG_COUNT:  bus_rdata = count;
            default:    bus_rdata = '0;
        endcase
    end

    assign wdt_irq     = flag_q;
    assign wdt_rst_req = rst_req_q;

    p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(fault && rst_act_q)) |=> en_q)
        else $error("enable dropped without a reset fault");
    p_arm_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(en_q && feed_good))
        else $error("became active without enable and feed");
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_ctrl && bus_wdata[CTRL_FLAG_BIT])) |=> flag_q)
        else $error("flag cleared without software");
    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req)
        else $error("reset request longer than one cycle");
    p_fault_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!active_q && flag_q))
        else $error("fault did not stop the watchdog");
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
    import wdt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FLOOR      = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        wdt_irq, wdt_rst_req;
    int          checks = 0;
    int          fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard u_wdt_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_irq     (wdt_irq),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_access(input logic [1:0] a);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic feed();
        wr(REG_FEED, 32'hAA);
        wr(REG_FEED, 32'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        int rl [6] = '{0, 1, 255, 256, 257, 300};
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(REG_CTRL, v);   chk("R1 ctrl", v, 0);
        peek(REG_COUNT, v);  chk("R1 count", v, 0);
        peek(REG_RELOAD, v); chk("R1 reload", v, 32'hFFFF_FFFF);
        chk("R1 irq", wdt_irq, 0);
        chk("R1 rst_req", wdt_rst_req, 0);

        // R6: bad key while inactive is ignored
        wr(REG_FEED, 32'h12);
        chk("R6 inactive bad ignored", wdt_irq, 0);

        // R7: enable with reset mode, no feed -> nothing runs
        wr(REG_RELOAD, 300);
        wr(REG_CTRL, 32'h3);
        step(50);
        peek(REG_COUNT, v); chk("R7 count idle before feed", v, 0);
        peek(REG_CTRL, v);  chk("R7 not active", v, 32'h3);

        // R2: writing 0 keeps enable; switch to interrupt mode
        wr(REG_CTRL, 32'h0);
        peek(REG_CTRL, v);  chk("R2 enable sticky", v[0], 1);
        wr(REG_CTRL, 32'h1);

        // R3/R4/R8/R9/R10 sweep over reload values in interrupt mode
        foreach (rl[i]) begin
            int eff;
            eff = (rl[i] < FLOOR) ? FLOOR : rl[i];
            wr(REG_RELOAD, rl[i]);
            peek(REG_RELOAD, v); chk("R3 reload raw", v, rl[i]);
            feed();
            peek(REG_COUNT, v); chk("R3 loaded count", v, eff);
            peek(REG_CTRL, v);  chk("R7 active after feed", v[3], 1);
            step(4);
            peek(REG_COUNT, v); chk("R4 first step", v, eff - 1);
            step(4 * eff - 5);
            chk("R4 no flag early", wdt_irq, 0);
            peek(REG_COUNT, v); chk("R4 count one", v, 1);
            step(1);
            chk("R4 flag at 4L", wdt_irq, 1);
            chk("R9 no reset in irq mode", wdt_rst_req, 0);
            peek(REG_COUNT, v); chk("R4 count zero", v, 0);
            peek(REG_CTRL, v);  chk("R9 irq-mode ctrl", v, 32'h5);
            step(8);
            peek(REG_COUNT, v); chk("R10 holds", v, 0);
            wr(REG_CTRL, 32'h1);
            chk("R8 flag kept", wdt_irq, 1);
            wr(REG_CTRL, 32'h5);
            chk("R8 flag cleared", wdt_irq, 0);
        end

        // R5: refeed mid-count restores the load
        wr(REG_RELOAD, 300);
        feed();
        step(400);
        peek(REG_COUNT, v); chk("R5 mid count", v, 200);
        feed();
        peek(REG_COUNT, v); chk("R5 reloaded", v, 300);
        step(4);
        peek(REG_COUNT, v); chk("R5 phase restart", v, 299);

        // R6: first key then a read access
        wr(REG_FEED, 32'hAA);
        rd_access(REG_CTRL);
        chk("R6 read between keys", wdt_irq, 1);
        peek(REG_COUNT, held);
        step(8);
        peek(REG_COUNT, v); chk("R10 stopped after bad feed", v, held);
        peek(REG_CTRL, v);  chk("R10 inactive", v[3], 0);
        wr(REG_CTRL, 32'h5);

        // R6: second key first
        feed();
        wr(REG_FEED, 32'h55);
        chk("R6 wrong first byte", wdt_irq, 1);
        wr(REG_CTRL, 32'h5);

        // R6: first key twice
        feed();
        wr(REG_FEED, 32'hAA);
        wr(REG_FEED, 32'hAA);
        chk("R6 double first key", wdt_irq, 1);
        wr(REG_CTRL, 32'h5);

        // R9: reset mode fault
        wr(REG_CTRL, 32'h3);
        feed();
        wr(REG_FEED, 32'h00);
        chk("R9 reset pulse", wdt_rst_req, 1);
        chk("R9 irq", wdt_irq, 1);
        peek(REG_CTRL, v);  chk("R9 enable cleared", v, 32'h6);
        step(1);
        chk("R9 pulse one cycle", wdt_rst_req, 0);
        peek(REG_COUNT, held);
        feed();
        peek(REG_CTRL, v);  chk("R7 no arm when disabled", v[3], 0);
        peek(REG_COUNT, v); chk("R7 count untouched", v, held);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule